// File: doc/BRIEF.md
# Address-Triggered Bus Takeover Controller

This block sits next to an 8-bit processor that runs from two quadrature phase clocks, E and Q. It watches the processor's address, data and read/write lines on a fast system clock. When software touches a fixed trigger address and then fetches a no-operation opcode, the block pulls the processor's active-low halt line. Once the bus is free, it grants the bus to a transfer engine. When the engine reports that it is finished, the block releases the halt and returns to idle.

The two-step trigger exists because the processor samples its halt input late. A halt raised during the last cycle of the triggering instruction would only take effect after the next instruction. Requiring a following no-operation fetch means that the instruction run before the halt is harmless. A build-time parameter chooses how bus release is detected. One variant waits for both bus-status inputs to be high. The other counts a fixed number of falling E edges after the halt is asserted.

Top module: `bus_takeover_ctrl`

## Requirements
- R1: While `rst_ni` is low and directly after it rises, `halt_no` is 1, `grant_o` is 0 and `busy_o` is 0, and no trigger is armed.
- R2: A bus cycle, read or write, whose address equals `TRIG_ADDR` (default 16'hFF61) when E falls arms the sequence. Arming by itself changes none of the outputs.
- R3: While armed, the first later read cycle (`rw_i`=1) decides the outcome. If `data_i` equals `NOP_OP` (default 8'h12) at falling E, `halt_no` goes low on the clock after that edge. Any other value clears the arm with no visible effect. Write cycles while armed leave the arm in place.
- R4: Once asserted, `halt_no` stays low until the release of R7, and `grant_o` is only ever high while `halt_no` is low.
- R5: With `USE_STATUS`=1, `grant_o` rises on the clock after a clock edge at which `halt_no` is low and `ba_i` and `bs_i` are both sampled high. Either one high on its own does not grant.
- R6: With `USE_STATUS`=0, `grant_o` rises on the clock after the `HOLDOFF`-th falling E edge (default 3) that is sampled after the edge that asserted the halt. `ba_i` and `bs_i` are ignored.
- R7: A `done_i` sampled high while granted schedules the release. At the first rising Q edge sampled on a later clock, `halt_no` returns to 1 and `grant_o` and `busy_o` drop to 0, all on the same clock.
- R8: `busy_o` is high exactly while `halt_no` is low.
- R9: Trigger addresses and opcodes seen while busy are ignored. After a release, a no-operation read with no new trigger does not start a takeover.
- R10: `done_i` has no effect while the bus is not yet granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than E/Q |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Processor address bus |
| data_i | input | DATA_W | Processor data bus |
| rw_i | input | 1 | 1 = read cycle, 0 = write cycle |
| e_i | input | 1 | Processor E phase |
| q_i | input | 1 | Processor Q phase |
| ba_i | input | 1 | Bus-available status (used when USE_STATUS=1) |
| bs_i | input | 1 | Bus-state status (used when USE_STATUS=1) |
| done_i | input | 1 | Transfer engine finished |
| halt_no | output | 1 | Active-low halt request to the processor |
| grant_o | output | 1 | Bus grant level to the transfer engine |
| busy_o | output | 1 | Takeover in progress |

## Verification
The assertions assume the following about the inputs:
- E and Q change slowly compared with `clk_i`.
- Address, data and read/write stay stable from the start of a bus cycle through the clock that samples falling E.
- The status pair only rises after the halt is asserted.

The stimulus keeps to these assumptions. Every bus cycle spans five system clocks, with Q leading E. The address and data lines are set at the start of each cycle and held across it. The status inputs are raised only from within a takeover. The done input comes from a small responder that reacts to the grant, plus one deliberately early pulse.

// File: rtl/bto_pkg.sv
package bto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2,
    ST_REL   = 2'd3
  } bto_state_e;
endpackage

// File: rtl/bto_phase_edges.sv
module bto_phase_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic e_i,
  input  logic q_i,
  output logic e_fall_o,
  output logic q_rise_o
);
  logic e_q, q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q <= 1'b0;
      q_q <= 1'b0;
    end else begin
      e_q <= e_i;
      q_q <= q_i;
    end
  end

  assign e_fall_o = e_q & ~e_i;
  assign q_rise_o = ~q_q & q_i;
endmodule

// File: rtl/bto_arm_seq.sv
module bto_arm_seq #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] TRIG_ADDR = 16'hFF61,
  parameter logic [7:0]  NOP_OP    = 8'h12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idle_i,
  input  logic              e_fall_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  output logic              start_o
);
  localparam logic [ADDR_W-1:0] TRIG = ADDR_W'(TRIG_ADDR);
  localparam logic [DATA_W-1:0] NOP  = DATA_W'(NOP_OP);

  logic armed_q;
  logic decide;

  // first read after arming is the opcode fetch
  assign decide  = armed_q & e_fall_i & rw_i;
  assign start_o = idle_i & decide & (data_i == NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  armed_q <= 1'b0;
    else if (!idle_i)                             armed_q <= 1'b0;
    else if (decide)                              armed_q <= 1'b0;
    else if (e_fall_i && addr_i == TRIG)          armed_q <= 1'b1;
  end

  AST_NO_ARM_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> !armed_q); // R9
endmodule

// File: rtl/bto_release_gate.sv
module bto_release_gate #(
  parameter bit USE_STATUS = 1'b1,
  parameter int HOLDOFF    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic waiting_i,
  input  logic e_fall_i,
  input  logic ba_i,
  input  logic bs_i,
  output logic ready_o
);
  localparam int CNT_W = (HOLDOFF < 2) ? 1 : $clog2(HOLDOFF);

  generate
    if (USE_STATUS) begin : g_status
      assign ready_o = waiting_i & ba_i & bs_i;
    end else begin : g_holdoff
      logic [CNT_W-1:0] cnt_q;

      assign ready_o = waiting_i & e_fall_i & (cnt_q == CNT_W'(HOLDOFF - 1));

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!waiting_i)  cnt_q <= '0;
        else if (e_fall_i && !ready_o) cnt_q <= cnt_q + 1'b1;
      end

      AST_HOLDOFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(cnt_q) < HOLDOFF); // R6
    end
  endgenerate
endmodule

// File: rtl/bus_takeover_ctrl.sv
module bus_takeover_ctrl
  import bto_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] TRIG_ADDR  = 16'hFF61,
  parameter logic [7:0]  NOP_OP     = 8'h12,
  parameter bit          USE_STATUS = 1'b1,
  parameter int          HOLDOFF    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rw_i,
  input  logic              e_i,
  input  logic              q_i,
  input  logic              ba_i,
  input  logic              bs_i,
  input  logic              done_i,
  output logic              halt_no,
  output logic              grant_o,
  output logic              busy_o
);
  bto_state_e state_q, state_d;
  logic e_fall, q_rise, start, ready;

  bto_phase_edges u_edges (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .e_i     (e_i),
    .q_i     (q_i),
    .e_fall_o(e_fall),
    .q_rise_o(q_rise)
  );

  bto_arm_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TRIG_ADDR(TRIG_ADDR),
    .NOP_OP   (NOP_OP)
  ) u_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idle_i  (state_q == ST_IDLE),
    .e_fall_i(e_fall),
    .addr_i  (addr_i),
    .data_i  (data_i),
    .rw_i    (rw_i),
    .start_o (start)
  );

  bto_release_gate #(
    .USE_STATUS(USE_STATUS),
    .HOLDOFF   (HOLDOFF)
  ) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .waiting_i(state_q == ST_WAIT),
    .e_fall_i (e_fall),
    .ba_i     (ba_i),
    .bs_i     (bs_i),
    .ready_o  (ready)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)  state_d = ST_WAIT;
      ST_WAIT:  if (ready)  state_d = ST_GRANT;
      ST_GRANT: if (done_i) state_d = ST_REL;
      ST_REL:   if (q_rise) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign halt_no = (state_q == ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE);
  assign grant_o = (state_q == ST_GRANT) || (state_q == ST_REL);

  AST_HALT_AFTER_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halt_no) |-> $past(rw_i && data_i == DATA_W'(NOP_OP))); // R3
  AST_GRANT_UNDER_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !halt_no); // R4
  AST_RELEASE_ON_Q: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_no) |-> $past(q_i) && !$past(q_i, 2)); // R7
  AST_GRANT_DROPS_WITH_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(grant_o) |-> $rose(halt_no)); // R7
  AST_GRANT_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_no) |-> $past(grant_o)); // R10

  generate
    if (USE_STATUS) begin : g_chk_status
      AST_GRANT_ON_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(grant_o) |-> $past(ba_i && bs_i)); // R5
    end
  endgenerate
endmodule

// File: tb/sim_bus_takeover_ctrl.sv
`timescale 1ns/1ps
module sim_bus_takeover_ctrl;
  localparam logic [15:0] TRIG = 16'hFF61;
  localparam logic [7:0]  NOP  = 8'h12;
  localparam int          HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic rw = 1'b1, e = 1'b0, q = 1'b0, ba = 1'b0, bs = 1'b0;
  logic done_force = 1'b0;
  logic [1:0] halt_n, grant, busy, done;
  int gcnt [2];

  int n_tests = 0, n_fail = 0;
  bit run_cmp = 1'b0;

  always #2.5 clk = ~clk;

  assign done[0] = (gcnt[0] == 5) | done_force;
  assign done[1] = (gcnt[1] == 5) | done_force;

  bus_takeover_ctrl #(.USE_STATUS(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .rw_i(rw),
    .e_i(e), .q_i(q), .ba_i(ba), .bs_i(bs), .done_i(done[0]),
    .halt_no(halt_n[0]), .grant_o(grant[0]), .busy_o(busy[0]));

  bus_takeover_ctrl #(.USE_STATUS(1'b0), .HOLDOFF(HOLD)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .rw_i(rw),
    .e_i(e), .q_i(q), .ba_i(ba), .bs_i(bs), .done_i(done[1]),
    .halt_no(halt_n[1]), .grant_o(grant[1]), .busy_o(busy[1]));

  // responder: done one clock after five granted clocks
  always @(negedge clk) begin
    for (int v = 0; v < 2; v++) gcnt[v] <= grant[v] ? gcnt[v] + 1 : 0;
  end

  // behavioural model: phase 0 idle, 1 halted, 2 granted, 3 leaving
  int  ph [2];
  bit  arm [2];
  int  falls [2];
  bit  m_ep, m_qp;
  always @(posedge clk) begin
    bit fe, qr;
    if (!rst_n) begin
      for (int v = 0; v < 2; v++) begin ph[v] = 0; arm[v] = 0; falls[v] = 0; end
      m_ep = 0; m_qp = 0;
    end else begin
      fe = m_ep && !e;
      qr = !m_qp && q;
      for (int v = 0; v < 2; v++) begin
        if (ph[v] == 0) begin
          falls[v] = 0;
          if (arm[v] && fe && rw) begin
            arm[v] = 0;
            if (data == NOP) ph[v] = 1;
          end else if (fe && addr == TRIG) arm[v] = 1;
        end else begin
          arm[v] = 0;
          if (ph[v] == 1) begin
            if (v == 0) begin
              if (ba && bs) ph[v] = 2;
            end else if (fe) begin
              falls[v]++;
              if (falls[v] == HOLD) ph[v] = 2;
            end
          end else if (ph[v] == 2) begin
            if (done[v]) ph[v] = 3;
          end else if (qr) ph[v] = 0;
        end
      end
      m_ep = e; m_qp = q;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      for (int v = 0; v < 2; v++) begin
        chk("R4 halt_no vs model", 8'(halt_n[v]), 8'(ph[v] == 0));
        chk(v == 0 ? "R5 grant vs model" : "R6 grant vs model",
            8'(grant[v]), 8'(ph[v] >= 2));
        chk("R8 busy vs model", 8'(busy[v]), 8'(ph[v] != 0));
      end
    end
  end

  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic r);
    @(negedge clk); addr = a; data = d; rw = r; e = 0; q = 1;
    @(negedge clk); e = 1; q = 1;
    @(negedge clk); e = 1; q = 0;
    @(negedge clk); e = 0; q = 0;
    @(negedge clk);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) bus_cycle(16'h2000, 8'h4F, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 halt_no in reset", 8'(halt_n), 8'h3);
    chk("R1 grant in reset", 8'(grant), 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 halt_no after reset", 8'(halt_n), 8'h3);
    chk("R1 busy after reset", 8'(busy), 8'h0);
    run_cmp = 1'b1;
    idle_cycles(2);

    // R2 arm by read, R3 non-NOP opcode disarms
    bus_cycle(TRIG, 8'h00, 1'b1);
    chk("R2 arming leaves halt_no", 8'(halt_n), 8'h3);
    bus_cycle(16'h1003, 8'h86, 1'b1);
    chk("R3 non-NOP no halt", 8'(halt_n), 8'h3);
    bus_cycle(16'h1004, NOP, 1'b1);
    chk("R3 disarmed NOP no halt", 8'(halt_n), 8'h3);

    // R2 arm by write, R3 write keeps arm, NOP starts takeover
    bus_cycle(TRIG, 8'h55, 1'b0);
    bus_cycle(16'h3000, 8'hAA, 1'b0);
    chk("R3 write while armed no halt", 8'(halt_n), 8'h3);
    bus_cycle(16'h1010, NOP, 1'b1);
    chk("R3 NOP starts halt", 8'(halt_n), 8'h0);
    chk("R8 busy with halt", 8'(busy), 8'h3);

    // R9 trigger and NOP while busy
    bus_cycle(TRIG, 8'h00, 1'b1);
    bus_cycle(16'h1011, NOP, 1'b1);
    idle_cycles(1);
    chk("R6 holdoff grant", 8'(grant[1]), 8'h1);
    chk("R5 no grant without status", 8'(grant[0]), 8'h0);
    ba = 1'b1;
    idle_cycles(1);
    chk("R5 ba alone no grant", 8'(grant[0]), 8'h0);
    chk("R4 halt held", 8'(halt_n[0]), 8'h0);
    bs = 1'b1;
    idle_cycles(1);
    chk("R5 grant on ba and bs", 8'(grant[0]), 8'h1);
    idle_cycles(4);
    chk("R7 halt released", 8'(halt_n), 8'h3);
    chk("R7 grant dropped", 8'(grant), 8'h0);
    ba = 1'b0; bs = 1'b0;
    bus_cycle(16'h1020, NOP, 1'b1);
    chk("R9 stale arm no halt", 8'(halt_n), 8'h3);

    // R10 early done ignored
    bus_cycle(TRIG, 8'h00, 1'b1);
    bus_cycle(16'h1030, NOP, 1'b1);
    @(negedge clk); done_force = 1'b1;
    @(negedge clk); done_force = 1'b0;
    @(negedge clk);
    chk("R10 early done halt kept", 8'(halt_n), 8'h0);
    chk("R10 early done no grant", 8'(grant), 8'h0);
    idle_cycles(3);
    ba = 1'b1; bs = 1'b1;
    idle_cycles(4);
    chk("R7 second release", 8'(halt_n), 8'h3);
    ba = 1'b0; bs = 1'b0;
    idle_cycles(2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule